// File: doc/BRIEF.md
# Pipelined Adder-Tree Sign Detector

This block takes a vector of signed samples that all arrive on the same clock and reports whether their sum is zero or positive. Each sample is widened to the sum width by sign extension. The widened samples are then reduced pairwise through a balanced binary tree of adders. A register bank sits after every adder level, so the depth of logic between flops is a single adder.

The output is one bit. It is the complement of the top bit of the 16-bit wrapped sum. A valid bit travels through a delay line that is as deep as the tree, so the flag and its qualifier leave the block together.

The block accepts a new vector on every clock and never stalls. A lane count that is not a power of two is handled by padding the tree with zero leaves. The latency is the number of tree levels, which grows with the logarithm of the lane count and not with the count itself.

Top module: `adder_tree_sign`

## Requirements
- R1: `in_data` carries `N_IN` lanes of `IN_W` (default 12) bits each, two's complement. Lane k occupies bits `[k*IN_W + IN_W-1 : k*IN_W]`, and every lane counts once in the sum.
- R2: Each lane is sign-extended to `SUM_W` (default 16) bits before it is added. The sum is taken modulo 2^SUM_W, so any sum outside the signed 16-bit range wraps.
- R3: `out_nonneg` is 1 exactly when bit `SUM_W-1` of the wrapped sum is 0. This is the case for a sum of zero, for a positive sum, and for a negative sum that wrapped to positive. The bit is 0 otherwise. It is never unknown while `out_valid` is 1.
- R4: The tree has `LVLS = ceil(log2(N_IN))` levels, with a minimum of 1. A vector sampled on a rising edge produces its result right after the `LVLS`-th rising edge, counting the sampling edge as the first. With the default `N_IN = 8` this is 3 edges; with `N_IN = 20` it is 5.
- R5: The initiation interval is one. Distinct vectors presented on consecutive cycles each yield their own result on consecutive cycles, and at most `LVLS` results are in flight.
- R6: `out_valid` repeats `in_valid` with the same latency as the data. It is 1 after `LVLS` consecutive valid inputs and 0 after `LVLS` consecutive idle inputs.
- R7: `rst` is synchronous and active high. It clears the valid pipeline: `out_valid` is 0 during reset and after it, until a vector presented after reset reaches the output. Any results that were in flight are dropped.
- R8: When `N_IN` is not a power of two, the unused leaves of the tree hold zero. The highest lane is summed like any other and adds no offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a vector to evaluate |
| in_data | input | N_IN*IN_W | Packed signed input lanes, lane 0 in the low bits |
| out_valid | output | 1 | Qualifies `out_nonneg` |
| out_nonneg | output | 1 | 1 when the wrapped sum is zero or positive |

## Verification
The bench goes after the sign boundary: a sum of exactly zero, a sum of minus one, and wide-instance sums of 32767 and 32768. A design that tested for strictly positive sums, or that kept more than 16 bits, would give the wrong flag at one of these points. Vectors of all 2047 and all -2048 on a 20-lane instance push the sum past the 16-bit range, which catches a design that saturates or keeps a wider sum instead of wrapping. A lane of -1 in isolation catches zero extension in place of sign extension. A single nonzero value in the top lane of the padded 20-lane tree catches misrouted or dropped leaves. Back-to-back streams with gaps in `in_valid`, and a reset while results are in flight, expose a valid line whose depth does not match the tree, or in-flight results that survive reset.

// File: rtl/adt_pkg.sv
`timescale 1ns/1ps
package adt_pkg;

  // Number of adder levels for n leaves; at least one level is always built.
  function automatic int tree_levels(input int n);
    int lv;
    lv = 0;
    while ((1 << lv) < n) lv++;
    if (lv == 0) lv = 1;
    return lv;
  endfunction

  // Leaf count of the balanced tree (power of two, at least 2).
  function automatic int tree_leaves(input int n);
    return 1 << tree_levels(n);
  endfunction

endpackage

// File: rtl/adt_leaf_prep.sv
`timescale 1ns/1ps
module adt_leaf_prep #(
  parameter int N_IN   = 8,
  parameter int IN_W   = 12,
  parameter int SUM_W  = 16,
  parameter int LEAVES = 8
) (
  input  logic [N_IN*IN_W-1:0]    lanes,
  output logic [LEAVES*SUM_W-1:0] leaves
);

  localparam int EXT_W = SUM_W - IN_W;

  // Widen one lane by replicating its sign bit.
  function automatic logic [SUM_W-1:0] widen(input logic [IN_W-1:0] x);
    return {{EXT_W{x[IN_W-1]}}, x};
  endfunction

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N_IN) begin : g_real
      assign leaves[i*SUM_W +: SUM_W] = widen(lanes[i*IN_W +: IN_W]);
    end else begin : g_pad
      // Missing leaves of a non-power-of-two tree contribute nothing.
      assign leaves[i*SUM_W +: SUM_W] = '0;
    end
  end

endmodule

// File: rtl/adt_add_level.sv
`timescale 1ns/1ps
module adt_add_level #(
  parameter int PAIRS = 1,
  parameter int SUM_W = 16
) (
  input  logic                     clk,
  input  logic [2*PAIRS*SUM_W-1:0] in_bus,
  output logic [PAIRS*SUM_W-1:0]   out_bus
);

  // Modulo-2^SUM_W addition: the carry out is dropped on purpose.
  function automatic logic [SUM_W-1:0] add_wrap(input logic [SUM_W-1:0] a,
                                                input logic [SUM_W-1:0] b);
    return a + b;
  endfunction

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [SUM_W-1:0] lhs;
    logic [SUM_W-1:0] rhs;
    logic [SUM_W-1:0] sum_d;
    logic [SUM_W-1:0] sum_q;

    assign lhs   = in_bus[(2*p)*SUM_W   +: SUM_W];
    assign rhs   = in_bus[(2*p+1)*SUM_W +: SUM_W];
    assign sum_d = add_wrap(lhs, rhs);

    // Data register: no reset, the valid line qualifies it.
    always_ff @(posedge clk) begin
      sum_q <= sum_d;
    end

    assign out_bus[p*SUM_W +: SUM_W] = sum_q;
  end

endmodule

// File: rtl/adt_valid_pipe.sv
`timescale 1ns/1ps
module adt_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic vout
);

  logic [DEPTH-1:0] stage_q;

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= vin;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= {stage_q[DEPTH-2:0], vin};
    end
  end

  assign vout = stage_q[DEPTH-1];

endmodule

// File: rtl/adder_tree_sign.sv
`timescale 1ns/1ps
module adder_tree_sign #(
  parameter int N_IN  = 8,
  parameter int IN_W  = 12,
  parameter int SUM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [N_IN*IN_W-1:0]  in_data,
  output logic                  out_valid,
  output logic                  out_nonneg
);

  import adt_pkg::*;

  localparam int LVLS   = tree_levels(N_IN);
  localparam int LEAVES = tree_leaves(N_IN);
  localparam int BUS_W  = LEAVES * SUM_W;

  // lvl_bus[l] holds the partial sums entering level l, zero above its width.
  logic [LVLS:0][BUS_W-1:0] lvl_bus;
  logic [SUM_W-1:0]         root_sum;
  logic                     root_msb;

  function automatic logic nonneg_of(input logic [SUM_W-1:0] s);
    return ~s[SUM_W-1];
  endfunction

  adt_leaf_prep #(
    .N_IN  (N_IN),
    .IN_W  (IN_W),
    .SUM_W (SUM_W),
    .LEAVES(LEAVES)
  ) u_prep (
    .lanes (in_data),
    .leaves(lvl_bus[0])
  );

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int PAIRS = LEAVES >> (l + 1);
    logic [PAIRS*SUM_W-1:0] dout;

    adt_add_level #(
      .PAIRS(PAIRS),
      .SUM_W(SUM_W)
    ) u_lvl (
      .clk    (clk),
      .in_bus (lvl_bus[l][2*PAIRS*SUM_W-1:0]),
      .out_bus(dout)
    );

    assign lvl_bus[l+1] = {{(BUS_W - PAIRS*SUM_W){1'b0}}, dout};
  end

  adt_valid_pipe #(
    .DEPTH(LVLS)
  ) u_vpipe (
    .clk (clk),
    .rst (rst),
    .vin (in_valid),
    .vout(out_valid)
  );

  assign root_sum   = lvl_bus[LVLS][SUM_W-1:0];
  assign root_msb   = root_sum[SUM_W-1];
  assign out_nonneg = nonneg_of(root_sum);

endmodule

// File: rtl/adt_checker.sv
`timescale 1ns/1ps
module adt_checker #(
  parameter int N_IN  = 8,
  parameter int IN_W  = 12,
  parameter int SUM_W = 16
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_nonneg,
  input logic [adt_pkg::tree_levels(N_IN):0][adt_pkg::tree_leaves(N_IN)*SUM_W-1:0] lvl_bus
);

  localparam int LVLS   = adt_pkg::tree_levels(N_IN);
  localparam int LEAVES = adt_pkg::tree_leaves(N_IN);
  localparam int BUS_W  = LEAVES * SUM_W;
  localparam int LANE_BITS = IN_W;

  function automatic logic [SUM_W-1:0] bus_sum(input logic [BUS_W-1:0] b);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LEAVES; i++) acc = acc + b[i*SUM_W +: SUM_W];
    return acc;
  endfunction

  function automatic logic msb_of(input logic [SUM_W-1:0] s);
    return s[SUM_W-1];
  endfunction

  int warm;      // edges seen since time zero, saturating
  int run_v;     // consecutive valid inputs since reset
  int run_i;     // consecutive idle inputs (reset counts as a full idle window)
  int inflight;  // valid inputs accepted but not yet delivered

  always_ff @(posedge clk) begin
    if (warm <= LVLS) warm <= warm + 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_v    <= 0;
      run_i    <= LVLS;
      inflight <= 0;
    end else begin
      run_v    <= in_valid ? ((run_v < LVLS) ? run_v + 1 : run_v) : 0;
      run_i    <= in_valid ? 0 : ((run_i < LVLS) ? run_i + 1 : run_i);
      inflight <= inflight + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
    end
  end

  // R4: each registered level passes the whole sum of the level below, one cycle later.
  for (genvar l = 0; l < LVLS; l++) begin : g_cons
    assert_tree_conserve_R4: assert property (@(posedge clk) disable iff (rst)
      (warm > l) |-> (bus_sum(lvl_bus[l+1]) == $past(bus_sum(lvl_bus[l]))));
  end

  assert_flag_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (warm >= LVLS) |-> (out_nonneg == !msb_of($past(bus_sum(lvl_bus[LVLS-1])))));

  assert_flag_known_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_nonneg));

  assert_reset_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_valid_run_R6: assert property (@(posedge clk) disable iff (rst)
    (run_v >= LVLS) |-> out_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (run_i >= LVLS) |-> !out_valid);

  assert_inflight_R5: assert property (@(posedge clk) disable iff (rst)
    (inflight >= 0) && (inflight <= LVLS));

  initial begin
    assert_lane_width_R1: assert (LANE_BITS < SUM_W);
  end

endmodule

bind adder_tree_sign adt_checker #(
  .N_IN (N_IN),
  .IN_W (IN_W),
  .SUM_W(SUM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_nonneg(out_nonneg),
  .lvl_bus   (lvl_bus)
);

// File: tb/tb_adder_tree_sign.sv
`timescale 1ns/1ps
module tb_adder_tree_sign;

  localparam int W  = 12;
  localparam int NA = 8;
  localparam int NB = 20;
  localparam int LA = 3;   // ceil(log2 8), R4
  localparam int LB = 5;   // ceil(log2 20), R4

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin = 1'b0;
  logic [NB*W-1:0] din = '0;
  logic va, fa, vb, fb;

  always #2 clk = ~clk;

  adder_tree_sign #(.N_IN(NA)) dut (
    .clk(clk), .rst(rst), .in_valid(vin), .in_data(din[NA*W-1:0]),
    .out_valid(va), .out_nonneg(fa));

  adder_tree_sign #(.N_IN(NB)) dut_wide (
    .clk(clk), .rst(rst), .in_valid(vin), .in_data(din),
    .out_valid(vb), .out_nonneg(fb));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [NB*W-1:0] vq [0:31];
  logic            vv [0:31];
  int              nv;

  // Reference: integer sum of the first n lanes, then the sign bit of its low 16 bits.
  function automatic logic ref_flag(input logic [NB*W-1:0] v, input int n);
    int s;
    logic [15:0] w;
    s = 0;
    for (int k = 0; k < n; k++) s += int'($signed(v[k*W +: W]));
    w = s[15:0];
    return !w[15];
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic set_lane(input int i, input int lane, input int val);
    vq[i][lane*W +: W] = val[W-1:0];
  endtask

  task automatic clear_q();
    for (int i = 0; i < 32; i++) begin
      vq[i] = '0;
      vv[i] = 1'b1;
    end
  endtask

  // Drives vq[0..nv-1] on consecutive cycles and checks both instances (R4 latency).
  task automatic run_batch(input string req);
    for (int c = 0; c < nv + LB; c++) begin
      int ia, ib;
      logic ea, eb;
      @(negedge clk);
      ia = c - LA;
      ib = c - LB;
      ea = (ia >= 0 && ia < nv) ? vv[ia] : 1'b0;
      eb = (ib >= 0 && ib < nv) ? vv[ib] : 1'b0;
      chk(req, "valid n8", va, ea);
      chk(req, "valid n20", vb, eb);
      if (ea) chk(req, "flag n8", fa, ref_flag(vq[ia], NA));
      if (eb) chk(req, "flag n20", fb, ref_flag(vq[ib], NB));
      if (c < nv) begin
        din = vq[c];
        vin = vv[c];
      end else begin
        din = '0;
        vin = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7", "valid in reset n8", va, 1'b0);
    chk("R7", "valid in reset n20", vb, 1'b0);
    rst = 1'b0;
  endtask

  // R3 boundary and R2 sign extension: zero, cancel, -1, +1.
  task automatic t_sign_edges();
    clear_q();
    nv = 4;
    set_lane(1, 0, 5);  set_lane(1, 1, -5);
    set_lane(2, 0, -1);
    set_lane(3, 0, 1);
    run_batch("R2 R3 zero/minus-one");
  endtask

  // R2 wrap: all-max, all-min, and the 32767/32768 edge on the wide instance.
  task automatic t_overflow();
    clear_q();
    nv = 4;
    for (int k = 0; k < NB; k++) begin
      set_lane(0, k, 2047);
      set_lane(1, k, -2048);
    end
    for (int k = 0; k < 16; k++) begin
      set_lane(2, k, 2047);
      set_lane(3, k, 2047);
    end
    set_lane(2, 16, 16);  // 32768: wraps negative
    set_lane(3, 16, 15);  // 32767: stays positive
    run_batch("R2 R3 overflow");
  endtask

  // R8 and R1: only the highest lane of the padded tree is nonzero.
  task automatic t_top_lane();
    clear_q();
    nv = 2;
    set_lane(0, NB-1, -7);
    set_lane(1, NB-1, -7);
    set_lane(1, 0, 6);
    set_lane(1, NA, 3);
    run_batch("R1 R8 top lane");
  endtask

  // R5: back-to-back random vectors, half of them with large magnitudes.
  task automatic t_stream();
    clear_q();
    nv = 24;
    for (int i = 0; i < nv; i++)
      for (int k = 0; k < NB; k++)
        set_lane(i, k, (i % 2 == 0) ? int'($urandom_range(4095)) :
                                      ((i % 4 == 1) ? 2000 - int'($urandom_range(60))
                                                    : -2000 + int'($urandom_range(60))));
    run_batch("R5 stream");
  endtask

  // R6: gaps in the valid input.
  task automatic t_gaps();
    clear_q();
    nv = 20;
    for (int i = 0; i < nv; i++) begin
      vv[i] = ((i % 3) != 1) && (i != 9) && (i != 10) && (i != 11);
      for (int k = 0; k < NB; k++) set_lane(i, k, int'($urandom_range(4095)));
    end
    run_batch("R6 gaps");
  endtask

  // R7: reset with results in flight.
  task automatic t_mid_reset();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      din = '0;
      din[W-1:0] = 12'd9;
      vin = 1'b1;
    end
    @(negedge clk);
    chk("R6", "first result before reset n8", va, 1'b1);
    vin = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < LB + 1; c++) begin
      chk("R7", "flushed n8", va, 1'b0);
      chk("R7", "flushed n20", vb, 1'b0);
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    repeat (LB + 1) @(negedge clk);
    t_sign_edges();
    t_overflow();
    t_top_lane();
    t_stream();
    t_gaps();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule